// File: doc/BRIEF.md
# Accelerometer Power-Mode Sequencer

This block decides the operating mode of a sensor's sampling core and converts that mode into the control signals used by the rest of the sensor. Software programs a set of configuration fields: a measure enable, a sleep request, an auto-sleep enable, a link enable, a two-bit wakeup code, and a normal-rate divider. From these fields and an inactivity indication the block chooses one of three modes: standby, normal measurement, or sleep.

A rate generator counts pulses of a reference tick and produces a one-cycle sample strobe at the cadence of the active mode. In sleep mode the core keeps refreshing its output data at a slow wakeup rate. During sleep the block hides the data-ready flag, stops FIFO writes, and leaves only the activity detector enabled. Auto-sleep puts the core to sleep when inactivity is reported, but only while linking is enabled.

Top module: `accel_power_seq`

## Requirements
- R1: After reset the block is in standby: `sampleStrobe`=0, `detectEn`=0, `fifoBlock`=1, `drdySuppress`=0.
- R2: While `measureEn`=0 (standby) no sample strobe is issued, `detectEn` is all zeros, `fifoBlock`=1 and `drdySuppress`=0.
- R3: In normal measurement mode (`measureEn`=1 and the effective sleep is 0) strobes occur every max(`normalDiv`,1) reference ticks, `drdySuppress`=0, `fifoBlock`=0 and `detectEn` is all ones.
- R4: In sleep mode (`measureEn`=1 and the effective sleep is 1) `drdySuppress`=1 and `fifoBlock`=1.
- R5: In sleep mode the strobe period is `WAKE_BASE_TICKS` << `wakeCode` reference ticks. Code 00 is the fastest rate (8 Hz) and each increment halves the rate: 01 is 4 Hz, 10 is 2 Hz, 11 is 1 Hz.
- R6: Sample strobes continue in sleep mode, so the output data keeps being refreshed even though data-ready is hidden.
- R7: In sleep mode `detectEn` has only bit `ACT_IDX` set (bit 0 by default, the activity detector).
- R8: The effective sleep is `sleepReq` | (`autoSleepEn` & `linkEn` & `inactiveIn`). When `linkEn`=0, `autoSleepEn` has no effect.
- R9: A new period (from a changed wakeup code, divider or mode) takes effect only at the next period boundary, so no partial period is produced. Each strobe lasts one cycle and follows a cycle in which `refTick` was high.
- R10: The mode outputs change one clock after the configuration inputs. On leaving standby the tick count restarts, so the first strobe comes a full period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| refTick | input | 1 | Reference tick pulse, one cycle wide |
| measureEn | input | 1 | 1 selects measurement, 0 selects standby |
| sleepReq | input | 1 | Manual sleep request |
| autoSleepEn | input | 1 | Auto-sleep enable |
| linkEn | input | 1 | Link enable; auto-sleep acts only when this is set |
| inactiveIn | input | 1 | Inactivity indication from the detector |
| wakeCode | input | 2 | Sleep-mode rate code |
| normalDiv | input | CNT_W | Normal-mode period in reference ticks (0 is treated as 1) |
| sampleStrobe | output | 1 | One-cycle sample strobe |
| drdySuppress | output | 1 | Hides the data-ready flag |
| fifoBlock | output | 1 | Blocks FIFO writes |
| detectEn | output | NUM_DET | Enable mask for the detection functions |

## Verification
On every cycle, the assertions check that the mode outputs follow the configuration one clock later. This covers the standby masking, the sleep gates, the activity-only mask, and auto-sleep being ignored without link. The assertions also check that a strobe never appears in standby and always follows a reference tick. The actual strobe spacing for each wakeup code and for the normal divider is shown only by the bench's scenarios. The same holds for the rule that a wakeup-code change waits for the period boundary, since both need whole periods to be measured.

// File: rtl/accel_power_seq_pkg.sv
package accel_power_seq_pkg;

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_NORMAL  = 2'd1,
    MODE_SLEEP   = 2'd2
  } pwrMode_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic run;      // rate generator counting
    logic useWake;  // select wakeup period at next boundary
  } seqCtl_t;

endpackage

// File: rtl/accel_power_seq_ctrl.sv
module accel_power_seq_ctrl
  import accel_power_seq_pkg::*;
#(
  parameter int NUM_DET = 4,
  parameter int ACT_IDX = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               measureEn,
  input  logic               sleepReq,
  input  logic               autoSleepEn,
  input  logic               linkEn,
  input  logic               inactiveIn,
  output seqCtl_t            seqCtl,
  output logic               drdySuppress,
  output logic               fifoBlock,
  output logic [NUM_DET-1:0] detectEn
);

  localparam logic [NUM_DET-1:0] ACT_ONLY = NUM_DET'(1) << ACT_IDX;
  localparam logic [NUM_DET-1:0] ALL_ON   = '1;

  pwrMode_t modeQ, modeD;
  logic     autoQual, effSleep;

  // auto-sleep is honoured only with link set
  assign autoQual = autoSleepEn & linkEn & inactiveIn;
  assign effSleep = sleepReq | autoQual;

  always_comb begin
    if (!measureEn)     modeD = MODE_STANDBY;
    else if (effSleep)  modeD = MODE_SLEEP;
    else                modeD = MODE_NORMAL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_STANDBY;
    else       modeQ <= modeD;
  end

  assign seqCtl.run     = (modeQ != MODE_STANDBY);
  assign seqCtl.useWake = (modeQ == MODE_SLEEP);

  always_comb begin
    unique case (modeQ)
      MODE_NORMAL: begin
        drdySuppress = 1'b0;
        fifoBlock    = 1'b0;
        detectEn     = ALL_ON;
      end
      MODE_SLEEP: begin
        drdySuppress = 1'b1;
        fifoBlock    = 1'b1;
        detectEn     = ACT_ONLY;
      end
      default: begin
        drdySuppress = 1'b0;
        fifoBlock    = 1'b1;
        detectEn     = '0;
      end
    endcase
  end

  // R2: standby masks everything one clock later
  a_r2_standby_masked: assert property (@(posedge clk) disable iff (!rstN)
    !measureEn |=> (detectEn == '0) && fifoBlock && !drdySuppress);

  // R4: sleep request gates data-ready and FIFO
  a_r4_sleep_gates: assert property (@(posedge clk) disable iff (!rstN)
    (measureEn && sleepReq) |=> drdySuppress && fifoBlock);

  // R7: only activity survives in sleep
  a_r7_activity_only: assert property (@(posedge clk) disable iff (!rstN)
    (measureEn && sleepReq) |=> (detectEn == ACT_ONLY));

  // R8: without link, auto-sleep cannot put the core to sleep
  a_r8_link_required: assert property (@(posedge clk) disable iff (!rstN)
    (measureEn && !sleepReq && !linkEn) |=> !drdySuppress && !fifoBlock);

endmodule

// File: rtl/accel_power_seq_rate.sv
module accel_power_seq_rate
  import accel_power_seq_pkg::*;
#(
  parameter int CNT_W           = 12,
  parameter int WAKE_BASE_TICKS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refTick,
  input  seqCtl_t          seqCtl,
  input  logic [1:0]       wakeCode,
  input  logic [CNT_W-1:0] normalDiv,
  output logic             sampleStrobe
);

  localparam logic [CNT_W-1:0] WAKE_BASE = CNT_W'(WAKE_BASE_TICKS);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  logic [CNT_W-1:0] cnt, periodLat, nextPeriod, wakePeriod, normPeriod;
  logic             lastTick;

  assign wakePeriod = WAKE_BASE << wakeCode;
  assign normPeriod = (normalDiv == '0) ? ONE : normalDiv;
  assign nextPeriod = seqCtl.useWake ? wakePeriod : normPeriod;
  assign lastTick   = (cnt >= periodLat - ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt          <= '0;
      periodLat    <= ONE;
      sampleStrobe <= 1'b0;
    end else begin
      sampleStrobe <= 1'b0;
      if (!seqCtl.run) begin
        cnt       <= '0;
        periodLat <= nextPeriod;
      end else if (refTick) begin
        if (lastTick) begin
          sampleStrobe <= 1'b1;
          cnt          <= '0;
          periodLat    <= nextPeriod;   // new period only at boundary
        end else begin
          cnt <= cnt + ONE;
        end
      end
    end
  end

  // R2: no strobe once standby is seen
  a_r2_no_strobe_standby: assert property (@(posedge clk) disable iff (!rstN)
    !seqCtl.run |=> !sampleStrobe);

  // R9: strobe always follows a reference tick
  a_r9_strobe_after_tick: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |-> $past(refTick));

  // R9: strobe is a single-cycle pulse
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |=> !sampleStrobe || $past(refTick));

endmodule

// File: rtl/accel_power_seq.sv
module accel_power_seq
  import accel_power_seq_pkg::*;
#(
  parameter int CNT_W           = 12,
  parameter int WAKE_BASE_TICKS = 4,
  parameter int NUM_DET         = 4,
  parameter int ACT_IDX         = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refTick,
  input  logic               measureEn,
  input  logic               sleepReq,
  input  logic               autoSleepEn,
  input  logic               linkEn,
  input  logic               inactiveIn,
  input  logic [1:0]         wakeCode,
  input  logic [CNT_W-1:0]   normalDiv,
  output logic               sampleStrobe,
  output logic               drdySuppress,
  output logic               fifoBlock,
  output logic [NUM_DET-1:0] detectEn
);

  seqCtl_t seqCtl;

  accel_power_seq_ctrl #(
    .NUM_DET (NUM_DET),
    .ACT_IDX (ACT_IDX)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .measureEn    (measureEn),
    .sleepReq     (sleepReq),
    .autoSleepEn  (autoSleepEn),
    .linkEn       (linkEn),
    .inactiveIn   (inactiveIn),
    .seqCtl       (seqCtl),
    .drdySuppress (drdySuppress),
    .fifoBlock    (fifoBlock),
    .detectEn     (detectEn)
  );

  accel_power_seq_rate #(
    .CNT_W           (CNT_W),
    .WAKE_BASE_TICKS (WAKE_BASE_TICKS)
  ) u_rate (
    .clk          (clk),
    .rstN         (rstN),
    .refTick      (refTick),
    .seqCtl       (seqCtl),
    .wakeCode     (wakeCode),
    .normalDiv    (normalDiv),
    .sampleStrobe (sampleStrobe)
  );

endmodule

// File: tb/accel_power_seq_tb.sv
module accel_power_seq_tb;

  localparam int CNT_W   = 12;
  localparam int WB      = 4;
  localparam int NDET    = 4;
  localparam int REF_DIV = 4;   // clocks per reference tick

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refTick = 1'b0;
  logic measureEn = 1'b0, sleepReq = 1'b0, autoSleepEn = 1'b0;
  logic linkEn = 1'b0, inactiveIn = 1'b0;
  logic [1:0] wakeCode = 2'b00;
  logic [CNT_W-1:0] normalDiv = CNT_W'(3);
  logic sampleStrobe, drdySuppress, fifoBlock;
  logic [NDET-1:0] detectEn;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int refDiv = 0;

  always #2.5 clk = ~clk;

  accel_power_seq #(.CNT_W(CNT_W), .WAKE_BASE_TICKS(WB), .NUM_DET(NDET), .ACT_IDX(0)) u_dut (
    .clk(clk), .rstN(rstN), .refTick(refTick), .measureEn(measureEn), .sleepReq(sleepReq),
    .autoSleepEn(autoSleepEn), .linkEn(linkEn), .inactiveIn(inactiveIn), .wakeCode(wakeCode),
    .normalDiv(normalDiv), .sampleStrobe(sampleStrobe), .drdySuppress(drdySuppress),
    .fifoBlock(fifoBlock), .detectEn(detectEn));

  always @(negedge clk) begin
    refDiv  <= (refDiv == REF_DIV - 1) ? 0 : refDiv + 1;
    refTick <= (refDiv == REF_DIV - 1);
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: all requirements, actual cycles=%0d expected <150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // cycles between two consecutive strobes; -1 on timeout
  task automatic measureGap(output int gap);
    int t;
    t = 0;
    gap = -1;
    do begin @(negedge clk); t++; end while (!sampleStrobe && t < 2000);
    if (!sampleStrobe) return;
    t = 0;
    do begin @(negedge clk); t++; end while (!sampleStrobe && t < 2000);
    if (sampleStrobe) gap = t;
  endtask

  task automatic t_reset();
    waitCyc(1);
    check("R1 strobe", sampleStrobe, 0);
    check("R1 detectEn", detectEn, 0);
    check("R1 fifoBlock", fifoBlock, 1);
    check("R1 drdySuppress", drdySuppress, 0);
  endtask

  task automatic t_standby();
    int seen;
    seen = 0;
    measureEn = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (sampleStrobe) seen++;
    end
    check("R2 strobes in standby", seen, 0);
    check("R2 detectEn", detectEn, 0);
    check("R2 fifoBlock", fifoBlock, 1);
  endtask

  task automatic t_normal();
    int g;
    sleepReq = 1'b0; normalDiv = CNT_W'(3);
    measureEn = 1'b1;
    @(negedge clk);
    check("R10 mode after one clock", detectEn, 4'hF);
    measureGap(g);
    check("R3 gap div=3", g, 3 * REF_DIV);
    check("R3 drdySuppress", drdySuppress, 0);
    check("R3 fifoBlock", fifoBlock, 0);
    normalDiv = '0;
    measureGap(g); measureGap(g);
    check("R3 gap div=0", g, REF_DIV);
  endtask

  task automatic t_sleepRates();
    int g;
    sleepReq = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R4 drdySuppress", drdySuppress, 1);
    check("R4 fifoBlock", fifoBlock, 1);
    check("R7 activity only", detectEn, 4'b0001);
    for (int c = 0; c < 4; c++) begin
      wakeCode = 2'(c);
      measureGap(g); measureGap(g);
      check("R5 R6 wake gap", g, (WB * REF_DIV) << c);
    end
  endtask

  task automatic t_wakeChange();
    int g, t;
    wakeCode = 2'b00;
    measureGap(g); measureGap(g);
    t = 0;
    do begin @(negedge clk); t++; end while (!sampleStrobe && t < 2000);
    t = 0;
    do begin
      @(negedge clk); t++;
      if (t == 5) wakeCode = 2'b11;
    end while (!sampleStrobe && t < 2000);
    check("R9 old period kept", t, WB * REF_DIV);
    t = 0;
    do begin @(negedge clk); t++; end while (!sampleStrobe && t < 2000);
    check("R9 new period at boundary", t, (WB * REF_DIV) << 3);
  endtask

  task automatic t_autoSleep();
    int g;
    sleepReq = 1'b0; wakeCode = 2'b00; normalDiv = CNT_W'(3);
    autoSleepEn = 1'b1; inactiveIn = 1'b1; linkEn = 1'b0;
    measureGap(g); measureGap(g);
    check("R8 no link: not suppressed", drdySuppress, 0);
    check("R8 no link: normal gap", g, 3 * REF_DIV);
    linkEn = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R8 link: suppressed", drdySuppress, 1);
    check("R8 link: activity only", detectEn, 4'b0001);
    measureGap(g); measureGap(g);
    check("R8 link: wake gap", g, WB * REF_DIV);
    inactiveIn = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R8 activity resumes normal", fifoBlock, 0);
    measureEn = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R2 back to standby", detectEn, 0);
  endtask

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    t_reset();
    t_standby();
    t_normal();
    t_sleepRates();
    t_wakeChange();
    t_autoSleep();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule